// File: doc/BRIEF.md
# Serial Unlock Key Detector

This block sits beside a byte-wide memory and watches its bus cycles. Each cycle is marked by a valid strobe and a read/write flag, and the block samples only bit 0 of the write data. A 64-bit unlock key has to arrive one bit per write cycle, through consecutive matching writes. The address of those writes does not matter. While the key is being collected, the memory keeps serving every access. The block only tracks how far the key has matched.

When the last key bit matches, the block raises a one-clock unlock pulse. It then opens a transfer window that spans the next 64 bus cycles. During the window a memory-block signal tells the memory to refuse access, and each bus cycle is flagged, with its bit index, as belonging to a serial register transfer engine. When the window closes, the detector is armed again from key bit 0. A read cycle outside the window always restarts the key from bit 0. The first mismatching write makes the detector ignore every later write until a read arrives.

Top module: `unlock_seq_detector`

## Requirements
- R1: After reset, unlock, mem_block and xfer_cycle are 0, and the detector expects key bit 0.
- R2: The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C, taken first byte first and least significant bit first, so write number i must carry bit i of 64'h5CA33AC55CA33AC5 on data_bit0. If 64 such writes arrive without a read or a mismatch, unlock is 1 in the clock that follows the edge accepting the 64th write.
- R3: A write whose data_bit0 differs from the expected key bit locks the detector. Later writes, including correct ones, cannot cause an unlock until a read arrives.
- R4: A read cycle outside the transfer window clears the match progress and any lockout. After the read, the key must be sent again from bit 0.
- R5: Clocks with cyc_valid low change neither the match progress nor the transfer window.
- R6: unlock is high for exactly one clock. From that same clock, the transfer window lasts exactly 64 valid bus cycles. During the window, xfer_cycle equals cyc_valid and xfer_index counts 0 to 63 over the window's cycles.
- R7: Bus cycles inside the window, whether reads or writes and with any data, do not count toward a new key. When the window closes, the detector expects key bit 0.
- R8: mem_block is 1 exactly while the transfer window is open. It is 0 while the key is being collected, so that traffic passes to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | A bus cycle is presented in this clock |
| cyc_write | input | 1 | 1 for a write cycle, 0 for a read cycle |
| data_bit0 | input | 1 | Bit 0 of the data bus |
| unlock | output | 1 | One-clock pulse when the full key has matched |
| mem_block | output | 1 | Memory access is inhibited (transfer window open) |
| xfer_cycle | output | 1 | The present bus cycle belongs to the register transfer |
| xfer_index | output | 6 | Bit position of the present transfer cycle |

## Verification
The case hardest to reach from the ports is a lockout that is followed by the correct remaining key bits. From outside, this looks like an almost complete key, and only the absence of an unlock shows that the mismatch was remembered. Directed sequences inject one flipped bit or one early read at a chosen key position and then send the rest of the key. Random sequences send keys with occasional corrupted bits, stray reads and idle gaps, and check every clock against a cycle model of the key rules.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
    localparam int unsigned DEF_KEY_LEN  = 64;
    localparam int unsigned DEF_XFER_LEN = 64;
    localparam logic [63:0] DEF_KEY      = 64'h5CA33AC5_5CA33AC5;
endpackage

// File: rtl/unlock_key_rom.sv
module unlock_key_rom #(
    parameter int unsigned       KEY_LEN = 64,
    parameter logic [KEY_LEN-1:0] KEY    = '0,
    localparam int unsigned      PW      = $clog2(KEY_LEN)
) (
    input  logic [PW-1:0] idx,
    output logic          key_bit
);
    logic [KEY_LEN-1:0] key_vec;

    for (genvar g = 0; g < KEY_LEN; g++) begin : g_bit
        assign key_vec[g] = KEY[g];
    end

    assign key_bit = key_vec[idx];
endmodule

// File: rtl/unlock_key_tracker.sv
module unlock_key_tracker #(
    parameter int unsigned KEY_LEN = 64,
    localparam int unsigned PW     = $clog2(KEY_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          cyc_valid,
    input  logic          cyc_write,
    input  logic          data_bit,
    input  logic          key_bit,
    output logic [PW-1:0] ptr,
    output logic          key_hit,
    output logic          unlock_q_o
);
    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          locked;
        logic          unlock;
    } trk_t;

    localparam logic [PW-1:0] LAST = PW'(KEY_LEN - 1);

    trk_t st_q, st_d;
    logic take_wr, take_rd, bit_ok;

    always_comb begin
        take_wr = enable && cyc_valid && cyc_write;
        take_rd = enable && cyc_valid && !cyc_write;
        bit_ok  = (data_bit == key_bit);
        key_hit = take_wr && !st_q.locked && bit_ok && (st_q.ptr == LAST);
        st_d        = st_q;
        st_d.unlock = 1'b0;
        if (take_rd) begin
            st_d.ptr    = '0;
            st_d.locked = 1'b0;
        end else if (take_wr && !st_q.locked) begin
            if (!bit_ok) begin
                st_d.locked = 1'b1;
            end else if (st_q.ptr == LAST) begin
                st_d.ptr    = '0;
                st_d.unlock = 1'b1;
            end else begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr        = st_q.ptr;
    assign unlock_q_o = st_q.unlock;

    a_r4_read_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cyc_valid && !cyc_write) |=> (st_q.ptr == '0 && !st_q.locked));
    a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.locked && !(enable && cyc_valid && !cyc_write)) |=> (st_q.locked && $stable(st_q.ptr)));
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && cyc_valid && cyc_write && !st_q.locked && data_bit == key_bit && st_q.ptr != LAST)
        |=> (st_q.ptr == $past(st_q.ptr) + 1'b1));
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.unlock |=> !st_q.unlock);
    a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> ($stable(st_q.ptr) && $stable(st_q.locked)));
endmodule

// File: rtl/unlock_xfer_window.sv
module unlock_xfer_window #(
    parameter int unsigned XFER_LEN = 64,
    localparam int unsigned CW      = $clog2(XFER_LEN + 1),
    localparam int unsigned IW      = $clog2(XFER_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          cyc_valid,
    output logic          busy,
    output logic [IW-1:0] index
);
    typedef struct packed {
        logic [CW-1:0] left;
    } win_t;

    localparam logic [CW-1:0] FULL = CW'(XFER_LEN);

    win_t st_q, st_d;
    logic [CW-1:0] done_cnt;

    always_comb begin
        st_d = st_q;
        if (start)                            st_d.left = FULL;
        else if (st_q.left != '0 && cyc_valid) st_d.left = st_q.left - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_cnt = FULL - st_q.left;
    assign busy     = (st_q.left != '0);
    assign index    = busy ? done_cnt[IW-1:0] : '0;

    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (st_q.left == '0));
    a_r6_load_full: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.left == FULL));
    a_r5_window_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_valid && !start) |=> $stable(st_q.left));
endmodule

// File: rtl/unlock_seq_detector.sv
module unlock_seq_detector #(
    parameter int unsigned        KEY_LEN   = unlock_pkg::DEF_KEY_LEN,
    parameter int unsigned        XFER_LEN  = unlock_pkg::DEF_XFER_LEN,
    parameter logic [KEY_LEN-1:0] KEY_VALUE = KEY_LEN'(unlock_pkg::DEF_KEY),
    localparam int unsigned       PW        = $clog2(KEY_LEN),
    localparam int unsigned       IW        = $clog2(XFER_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cyc_valid,
    input  logic          cyc_write,
    input  logic          data_bit0,
    output logic          unlock,
    output logic          mem_block,
    output logic          xfer_cycle,
    output logic [IW-1:0] xfer_index
);
    logic [PW-1:0] ptr;
    logic          key_bit, key_hit, busy;

    unlock_key_rom #(.KEY_LEN(KEY_LEN), .KEY(KEY_VALUE)) u_rom (
        .idx(ptr), .key_bit(key_bit)
    );

    unlock_key_tracker #(.KEY_LEN(KEY_LEN)) u_trk (
        .clk(clk), .rst_n(rst_n), .enable(!busy),
        .cyc_valid(cyc_valid), .cyc_write(cyc_write), .data_bit(data_bit0),
        .key_bit(key_bit), .ptr(ptr), .key_hit(key_hit), .unlock_q_o(unlock)
    );

    unlock_xfer_window #(.XFER_LEN(XFER_LEN)) u_win (
        .clk(clk), .rst_n(rst_n), .start(key_hit), .cyc_valid(cyc_valid),
        .busy(busy), .index(xfer_index)
    );

    assign mem_block  = busy;
    assign xfer_cycle = busy && cyc_valid;

    a_r6_unlock_opens_window: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |-> (mem_block && xfer_index == '0));
    a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_block) |-> !unlock);
endmodule

// File: tb/unlock_seq_detector_test.sv
module unlock_seq_detector_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_valid = 1'b0, cyc_write = 1'b0, data_bit0 = 1'b0;
    logic unlock, mem_block, xfer_cycle;
    logic [5:0] xfer_index;

    int errors = 0, checks = 0;
    int m_ptr = 0, m_cnt = 0;
    bit m_lock = 0, m_unlock = 0;

    always #2 clk = ~clk;

    unlock_seq_detector uut (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_write(cyc_write),
        .data_bit0(data_bit0), .unlock(unlock), .mem_block(mem_block),
        .xfer_cycle(xfer_cycle), .xfer_index(xfer_index)
    );

    function automatic bit kb(int i);
        logic [7:0] b;
        case ((i / 8) % 4)
            0: b = 8'hC5;
            1: b = 8'h3A;
            2: b = 8'hA3;
            default: b = 8'h5C;
        endcase
        return b[i % 8];
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(bit v, bit w, bit b);
        m_unlock = 0;
        if (m_cnt > 0) begin
            if (v) m_cnt--;
        end else if (v) begin
            if (!w) begin m_ptr = 0; m_lock = 0; end
            else if (!m_lock) begin
                if (b == kb(m_ptr)) begin
                    if (m_ptr == 63) begin m_ptr = 0; m_unlock = 1; m_cnt = 64; end
                    else m_ptr++;
                end else m_lock = 1;
            end
        end
    endtask

    // called at negedge: drive, check comb outputs, clock, check registered outputs
    task automatic bus(bit v, bit w, bit b);
        cyc_valid = v; cyc_write = w; data_bit0 = b;
        #1;
        check(mem_block == (m_cnt > 0), "R8", mem_block, m_cnt > 0);
        check(xfer_cycle == (v && m_cnt > 0), "R6", xfer_cycle, v && m_cnt > 0);
        if (m_cnt > 0) check(xfer_index == 6'(64 - m_cnt), "R6", xfer_index, 64 - m_cnt);
        model_step(v, w, b);
        @(posedge clk); @(negedge clk);
        check(unlock == m_unlock, "R2", unlock, m_unlock);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) bus(0, $urandom_range(0, 1), $urandom_range(0, 1));
    endtask

    task automatic send_bits(int from, int to, bit gaps);
        for (int i = from; i <= to; i++) begin
            if (gaps && $urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
            bus(1, 1, kb(i));
        end
    endtask

    task automatic drain();
        while (m_cnt > 0) begin
            if ($urandom_range(0, 4) == 0) bus(0, 0, 0);
            else bus(1, $urandom_range(0, 1), $urandom_range(0, 1));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(unlock == 0, "R1", unlock, 0);
        check(mem_block == 0, "R1", mem_block, 0);
        check(xfer_cycle == 0, "R1", xfer_cycle, 0);

        // R2/R5: full key with idle gaps from reset
        send_bits(0, 63, 1);
        check(unlock == 1, "R2", unlock, 1);
        check(mem_block == 1, "R8", mem_block, 1);
        bus(0, 0, 0);
        check(unlock == 0, "R6", unlock, 0);

        // R6/R7: window fed with key bits, then exact length
        n = 0;
        for (int i = 0; i < 64; i++) begin
            if (mem_block) n++;
            bus(1, 1, kb(i));
        end
        check(n == 64, "R6", n, 64);
        check(mem_block == 0, "R6", mem_block, 0);
        check(unlock == 0, "R7", unlock, 0);
        send_bits(0, 63, 0);
        check(unlock == 1, "R7", unlock, 1);
        drain();

        // R3: mismatch at bit 10, rest correct -> no unlock
        bus(1, 0, 0);
        send_bits(0, 9, 0);
        bus(1, 1, !kb(10));
        send_bits(11, 63, 1);
        check(unlock == 0, "R3", unlock, 0);
        send_bits(0, 63, 0);
        check(unlock == 0, "R3", unlock, 0);
        bus(1, 0, 1);
        send_bits(0, 63, 0);
        check(unlock == 1, "R3", unlock, 1);
        drain();

        // R4: read mid-key, then the remainder only -> no unlock
        send_bits(0, 19, 0);
        bus(1, 0, 0);
        send_bits(20, 63, 0);
        check(unlock == 0, "R4", unlock, 0);
        bus(1, 0, 0);
        send_bits(0, 30, 0);
        bus(1, 0, 1);
        send_bits(0, 63, 1);
        check(unlock == 1, "R4", unlock, 1);
        drain();

        // random mix
        for (int s = 0; s < 400; s++) begin
            case ($urandom_range(0, 3))
                0: begin bus(1, 0, 0); send_bits(0, 63, 1); end
                1: begin
                    bus(1, 0, 0);
                    for (int i = 0; i < 64; i++) begin
                        if ($urandom_range(0, 9) == 0) idle(1);
                        if ($urandom_range(0, 79) == 0) bus(1, 0, 0);
                        else bus(1, 1, ($urandom_range(0, 63) == 0) ? !kb(i) : kb(i));
                    end
                end
                2: for (int i = 0; i < 20; i++)
                       bus($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
                default: drain();
            endcase
        end
        drain();
        idle(2);
        check(mem_block == 0, "R8", mem_block, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule